// File: doc/BRIEF.md
# Power-Fail Chip-Enable Controller

This block is the digital core of a supervisor that makes battery-backed static RAM behave as nonvolatile storage. While the supply is good, it steers one active-low chip-enable strobe onto one of several SRAM banks, chosen by a bank-select address field. Both analog comparator results arrive already digitised, one for a tight (5%) and one for a loose (10%) supply tolerance. A static strap picks which of the two counts.

When the selected flag reports a supply failure, the controller write-protects every bank. An access that was already running may finish, but only within a bounded number of cycles. No new access gets through. A system reset follows a fixed number of cycles after the failure. When the supply comes back, reset and write protection both stay in force for a recovery interval before normal decoding resumes. A further failure during that interval locks the banks again at once, and the next good supply restarts the interval from zero. All delays are counted in clock cycles.

Top module: `pwrfail_ce_ctrl`

## Requirements
- R1: In normal operation with `ce_n_i` high, every bit of `ce_bank_n_o` is high. With `ce_n_i` low, only bit `bank_sel_i` of `ce_bank_n_o` is low. Bit 0 is the bank for select value 0. Decoding is combinational and needs no setup time between `bank_sel_i` and `ce_n_i`.
- R2: `thr_sel_i` = 0 makes `pf_tight_i` the failure flag and `thr_sel_i` = 1 makes `pf_wide_i` the failure flag (1 = supply failed). The flag that is not selected has no effect on any output.
- R3: Suppose `ce_n_i` was low at the previous clock edge and is still low at the edge where a failure is first sampled. That access keeps passing to the selected bank until `ce_n_i` rises. From then on, all outputs are high.
- R4: An access held low after failure detection is cut off at the WP_CYC-th edge after the detecting edge. From that edge on, all of `ce_bank_n_o` is high, whatever `ce_n_i` does.
- R5: A chip enable that falls in the detection cycle, or at any time after protection is engaged, never drives any bit of `ce_bank_n_o` low until recovery completes.
- R6: If the supply stays failed, `sys_rst_o` rises at the RST_CYC-th edge after the edge that first samples the failure.
- R7: After the edge at which a locked controller samples a good supply, `sys_rst_o` stays high and all chip enables stay high for REC_CYC edges. At the REC_CYC-th edge, reset clears and R1 decoding resumes.
- R8: A failure sampled during recovery immediately relocks the banks with reset held. The next good supply starts a full REC_CYC recovery from zero.
- R9: While `rst_n` is low at a clock edge, `sys_rst_o` is high and all chip enables are high. After release, the R7 recovery sequence runs with its count starting at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_i | input | 1 | Active-low chip enable from the processor |
| bank_sel_i | input | BANK_W | Bank-select address field |
| thr_sel_i | input | 1 | Tolerance strap: 0 selects tight flag, 1 selects wide flag |
| pf_tight_i | input | 1 | Supply-failed flag, 5% comparator |
| pf_wide_i | input | 1 | Supply-failed flag, 10% comparator |
| ce_bank_n_o | output | NBANK | Conditioned active-low chip enables, one per bank |
| sys_rst_o | output | 1 | Active-high system reset |

## Verification
The bench targets the edge cases of the power-fail sequence. These are a chip enable falling in the same cycle the failure is first seen (a leaky design passes it), an access held past the timeout (a wrong counter cuts it one cycle early or late, or never), and a new strobe after an in-progress access ends (a design without a lock would let it through). It also checks a failure on the unselected comparator flag, which must be ignored. On the reset side, it watches the exact edge at which reset rises and the exact edge at which recovery ends, where an off-by-one counter shows up at once. A failure in mid-recovery must restart the full interval; a design that only paused its counter would release too early.

// File: rtl/pfce_pkg.sv
// Shared types for the power-fail chip-enable controller.
// Assumes nothing beyond a two-bit phase code.
package pfce_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,  // supply good, decoding live
        PH_DRAIN   = 2'd1,  // failure seen, in-flight access may finish
        PH_LOCK    = 2'd2,  // banks write-protected, supply still failed
        PH_RECOVER = 2'd3   // supply good, holding protection and reset
    } pfce_phase_e;

endpackage

// File: rtl/pfce_thr_mux.sv
// Picks the failure flag that matches the strapped supply tolerance.
// Assumes thr_sel_i is static while the system runs.
module pfce_thr_mux (
    input  logic thr_sel_i,
    input  logic flag_tight_i,
    input  logic flag_wide_i,
    output logic fail_o
);

    // Select the active comparator flag.
    always_comb begin
        fail_o = thr_sel_i ? flag_wide_i : flag_tight_i;
    end

endmodule

// File: rtl/pfce_seq.sv
// Phase sequencer: tracks supply state, bounds the drain of an in-flight
// access and times the recovery interval. Produces the pass-enable the
// bank decoder uses. Assumes WP_CYC >= 1 and REC_CYC >= 1.
module pfce_seq
    import pfce_pkg::*;
#(
    parameter int unsigned WP_CYC  = 12,
    parameter int unsigned REC_CYC = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fail_i,
    input  logic        ce_n_i,
    output pfce_phase_e ph_o,
    output pfce_phase_e ph_nxt_o,
    output logic        pass_o
);

    localparam int unsigned WP_W  = $clog2(WP_CYC + 1);
    localparam int unsigned REC_W = $clog2(REC_CYC + 1);
    localparam logic [WP_W-1:0]  WP_LAST  = WP_W'(WP_CYC - 1);
    localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_CYC - 1);

    pfce_phase_e      ph_q, ph_d;
    logic [WP_W-1:0]  wp_q, wp_d;
    logic [REC_W-1:0] rec_q, rec_d;
    logic             held_q;   // chip enable was low at the last edge

    // Next-phase and counter logic.
    always_comb begin
        ph_d  = ph_q;
        wp_d  = wp_q;
        rec_d = rec_q;
        unique case (ph_q)
            PH_RUN: begin
                if (fail_i) begin
                    wp_d = '0;
                    ph_d = (!ce_n_i && held_q) ? PH_DRAIN : PH_LOCK;
                end
            end
            PH_DRAIN: begin
                if (ce_n_i || wp_q == WP_LAST) ph_d = PH_LOCK;
                else                           wp_d = wp_q + 1'b1;
            end
            PH_LOCK: begin
                if (!fail_i) begin
                    ph_d  = PH_RECOVER;
                    rec_d = '0;
                end
            end
            PH_RECOVER: begin
                if (fail_i)                 ph_d  = PH_LOCK;
                else if (rec_q == REC_LAST) ph_d  = PH_RUN;
                else                        rec_d = rec_q + 1'b1;
            end
            default: ph_d = PH_LOCK;
        endcase
    end

    // Phase, counters and access-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_RECOVER;
            wp_q   <= '0;
            rec_q  <= '0;
            held_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            wp_q   <= wp_d;
            rec_q  <= rec_d;
            held_q <= !ce_n_i;
        end
    end

    // Strobe may pass: live decode, or an access that predates detection.
    always_comb begin
        pass_o = ((ph_q == PH_RUN) && (!fail_i || held_q)) ||
                 ((ph_q == PH_DRAIN) && !ce_n_i);
    end

    assign ph_o     = ph_q;
    assign ph_nxt_o = ph_d;

    // R4: the last drain cycle always ends in protection.
    p_drain_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DRAIN && wp_q == WP_LAST) |=> (ph_q == PH_LOCK));

    // R8: a failure during recovery relocks at the next edge.
    p_refail_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RECOVER && fail_i) |=> (ph_q == PH_LOCK));

    // R7: the final recovery count returns to normal operation.
    p_recover_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RECOVER && rec_q == REC_LAST && !fail_i) |=> (ph_q == PH_RUN));

endmodule

// File: rtl/pfce_rst_timer.sv
// Reset generator: raises system reset a fixed number of edges after a
// failure is detected and holds it through recovery.
// Assumes RST_CYC >= 1 and the phase inputs come from pfce_seq.
module pfce_rst_timer
    import pfce_pkg::*;
#(
    parameter int unsigned RST_CYC = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pfce_phase_e ph_i,
    input  pfce_phase_e ph_nxt_i,
    output logic        rst_o
);

    localparam int unsigned AGE_W = $clog2(RST_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RST_CYC);

    logic [AGE_W-1:0] age_q, age_d;
    logic             rst_q;

    // Edges since detection, saturating at the reset delay.
    always_comb begin
        if (ph_i == PH_RUN)        age_d = '0;
        else if (age_q == AGE_MAX) age_d = age_q;
        else                       age_d = age_q + 1'b1;
    end

    // Reset flag: sticky until the controller returns to normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
            rst_q <= 1'b1;
        end else if (ph_nxt_i == PH_RUN) begin
            age_q <= '0;
            rst_q <= 1'b0;
        end else begin
            age_q <= age_d;
            rst_q <= rst_q || (ph_nxt_i == PH_RECOVER) || (age_d >= AGE_MAX);
        end
    end

    assign rst_o = rst_q;

    // R6: reset is up once the delay count is reached.
    p_rst_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i != PH_RUN && ph_nxt_i != PH_RUN && age_q == AGE_W'(RST_CYC - 1)) |=> rst_o);

    // R7: reset is held throughout recovery.
    p_rst_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_RECOVER) |-> rst_o);

    // R7: reset clears when recovery ends.
    p_rst_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_RECOVER && ph_nxt_i == PH_RUN) |=> !rst_o);

endmodule

// File: rtl/pfce_bank_dec.sv
// Bank decoder: routes the active-low chip enable to the selected bank
// when the sequencer allows it. Select values beyond NBANK-1 match no bank.
module pfce_bank_dec #(
    parameter int unsigned NBANK = 2,
    localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             ce_n_i,
    input  logic             pass_i,
    input  logic [BW-1:0]    bank_i,
    output logic [NBANK-1:0] ce_bank_n_o
);

    // One comparator per bank output.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign ce_bank_n_o[g] = !(pass_i && !ce_n_i && (bank_i == BW'(g)));
    end

endmodule

// File: rtl/pwrfail_ce_ctrl.sv
// Power-fail chip-enable controller top. Chains threshold select,
// phase sequencer, reset timer and bank decoder. Inputs are assumed
// synchronous to clk; the comparator flags read 1 when the supply has failed.
module pwrfail_ce_ctrl
    import pfce_pkg::*;
#(
    parameter int unsigned  NBANK   = 2,
    parameter int unsigned  WP_CYC  = 12,
    parameter int unsigned  RST_CYC = 6,
    parameter int unsigned  REC_CYC = 40,
    localparam int unsigned BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic              thr_sel_i,
    input  logic              pf_tight_i,
    input  logic              pf_wide_i,
    output logic [NBANK-1:0]  ce_bank_n_o,
    output logic              sys_rst_o
);

    logic        fail;
    logic        pass;
    pfce_phase_e ph;
    pfce_phase_e ph_nxt;

    pfce_thr_mux i_thr (
        .thr_sel_i    (thr_sel_i),
        .flag_tight_i (pf_tight_i),
        .flag_wide_i  (pf_wide_i),
        .fail_o       (fail)
    );

    pfce_seq #(
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_i   (fail),
        .ce_n_i   (ce_n_i),
        .ph_o     (ph),
        .ph_nxt_o (ph_nxt),
        .pass_o   (pass)
    );

    pfce_rst_timer #(
        .RST_CYC (RST_CYC)
    ) i_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_i     (ph),
        .ph_nxt_i (ph_nxt),
        .rst_o    (sys_rst_o)
    );

    pfce_bank_dec #(
        .NBANK (NBANK)
    ) i_dec (
        .ce_n_i      (ce_n_i),
        .pass_i      (pass),
        .bank_i      (bank_sel_i),
        .ce_bank_n_o (ce_bank_n_o)
    );

    // R1: at most one bank is ever enabled.
    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_bank_n_o));

    // R1: an idle strobe enables no bank.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> (&ce_bank_n_o));

    // R5: protection or recovery keeps every bank disabled.
    p_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_LOCK || ph == PH_RECOVER) |-> (&ce_bank_n_o));

    // R9: a reset edge leaves reset asserted and banks disabled.
    p_sync_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (sys_rst_o && (&ce_bank_n_o)));

endmodule

// File: tb/test_pwrfail_ce_ctrl.sv
`timescale 1ns/1ps
module test_pwrfail_ce_ctrl;

    localparam int NB = 2;
    localparam int WP = 12;
    localparam int RD = 6;
    localparam int RC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic [0:0]    bank = 1'b0;
    logic          thr = 1'b0;
    logic          f5 = 1'b0;
    logic          f10 = 1'b0;
    logic [NB-1:0] ce_o;
    logic          rst_o;

    always #10 clk = ~clk;

    pwrfail_ce_ctrl #(.NBANK(NB), .WP_CYC(WP), .RST_CYC(RD), .REC_CYC(RC)) i_pwrfail_ce_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n_i      (ce_n),
        .bank_sel_i  (bank),
        .thr_sel_i   (thr),
        .pf_tight_i  (f5),
        .pf_wide_i   (f10),
        .ce_bank_n_o (ce_o),
        .sys_rst_o   (rst_o)
    );

    int    total = 0;
    int    bad = 0;
    string req = "R9";
    bit    finished = 0;

    // Behavioural model: mode 0 normal, 1 finishing access, 2 locked, 3 recovering.
    int m_mode = 3;
    int m_drain = 0;
    int m_age = 0;
    int m_rec = 0;
    bit m_rst = 1;
    bit m_prev = 0;
    bit fl;
    bit cl;

    // Advance the model on each rising edge from the driven inputs.
    always @(posedge clk) begin
        fl = thr ? f10 : f5;
        cl = !ce_n;
        if (!rst_n) begin
            m_mode = 3; m_rec = 0; m_age = 0; m_rst = 1;
        end else begin
            case (m_mode)
                0: if (fl) begin
                       m_mode = (cl && m_prev) ? 1 : 2;
                       m_drain = 0; m_age = 0;
                   end
                1: begin
                       m_age = (m_age < RD) ? m_age + 1 : RD;
                       if (!cl || m_drain == WP - 1) m_mode = 2;
                       else m_drain = m_drain + 1;
                   end
                2: begin
                       m_age = (m_age < RD) ? m_age + 1 : RD;
                       if (!fl) begin m_mode = 3; m_rec = 0; end
                   end
                default: begin
                       if (fl) m_mode = 2;
                       else if (m_rec == RC - 1) m_mode = 0;
                       else m_rec = m_rec + 1;
                   end
            endcase
            if (m_mode == 0) m_rst = 0;
            else if (m_mode == 3 || m_age >= RD) m_rst = 1;
        end
        m_prev = rst_n ? cl : 1'b0;
    end

    // Compare the outputs with the model's prediction.
    task automatic check();
        logic [NB-1:0] exp_ce;
        bit f, pass;
        f = thr ? f10 : f5;
        pass = (m_mode == 0 && (!f || m_prev)) || (m_mode == 1 && !ce_n);
        exp_ce = '1;
        if (pass && !ce_n) exp_ce[bank] = 1'b0;
        total++;
        if (ce_o !== exp_ce || rst_o !== m_rst) begin
            bad++;
            $display("FAIL %s: ce=%b rst=%b expected ce=%b rst=%b at %0t",
                     req, ce_o, rst_o, exp_ce, m_rst, $time);
        end
    endtask

    task automatic step(input bit c, input bit b, input bit t,
                        input bit p5, input bit p10, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_n = c; bank = b; thr = t; f5 = p5; f10 = p10;
            #2 check();
        end
    endtask

    initial begin
        // R9: reset state, then power-on recovery.
        req = "R9";
        rst_n = 1'b0;
        step(1, 0, 0, 0, 0, 3);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, RC + 2);

        // R1: decoding under several strobe and select patterns.
        req = "R1";
        step(0, 0, 0, 0, 0, 2);
        step(0, 1, 0, 0, 0, 2);
        step(1, 1, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 3);
        step(1, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 2);

        // R2: the unselected flag is ignored in both strap settings.
        req = "R2";
        step(0, 1, 0, 0, 1, 4);
        step(1, 0, 0, 0, 1, 1);
        step(0, 0, 1, 1, 0, 4);
        step(1, 0, 1, 1, 0, 1);

        // R5: failure while idle, then strobes while locked.
        req = "R5";
        step(1, 0, 1, 0, 1, 3);
        step(0, 1, 1, 0, 1, 5);
        req = "R7";
        step(1, 0, 1, 0, 0, RC + 2);

        // R5: a strobe falling in the detection cycle is blocked.
        req = "R5";
        step(1, 0, 0, 0, 0, 2);
        step(0, 0, 0, 1, 0, 3);
        req = "R7";
        step(1, 0, 0, 0, 0, RC + 2);

        // R3: an in-progress access finishes, then new strobes are blocked.
        req = "R3";
        step(0, 1, 0, 0, 0, 2);
        step(0, 1, 0, 1, 0, 5);
        step(1, 1, 0, 1, 0, 2);
        step(0, 1, 0, 1, 0, 3);
        req = "R7";
        step(1, 0, 0, 0, 0, RC + 2);

        // R4: an access held past the timeout is cut off.
        req = "R4";
        step(0, 0, 1, 0, 0, 2);
        step(0, 0, 1, 0, 1, WP + 6);
        req = "R7";
        step(1, 0, 1, 0, 0, RC + 2);

        // R6: reset rises at the delay while the supply stays failed.
        req = "R6";
        step(1, 0, 0, 1, 0, RD + 6);

        // R8: failure in mid-recovery relocks and restarts the count.
        req = "R8";
        step(1, 0, 0, 0, 0, 10);
        step(1, 0, 0, 1, 0, 2);
        step(1, 0, 0, 0, 0, 15);
        step(1, 0, 0, 1, 0, 1);
        step(1, 0, 0, 0, 0, RC + 3);
        req = "R7";
        step(0, 1, 0, 0, 0, 3);

        // R9: reset applied during normal decoding.
        req = "R9";
        rst_n = 1'b0;
        step(0, 1, 0, 0, 0, 2);
        rst_n = 1'b1;
        step(0, 1, 0, 0, 0, RC + 2);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule